// File: doc/BRIEF.md
# Fractional Clock Tick Divider

This block turns a fast system clock into a single-cycle enable tick whose average rate is the system clock divided by a mixed divisor N + b/a. N is the whole part of the divisor, and b/a is the fraction, with a denominator of at most 63. Most periods last N cycles. A fraction accumulator decides which periods are stretched to N + 1 cycles, so that over every a ticks the total time is exactly a·N + b cycles. No clock is gated and no PLL is involved: downstream logic runs on the same clock and qualifies its work with the tick. A typical use is the slot-rate enable of a serial waveform shaper. For example, an 80 MHz system clock with N = 10 and b = 0 gives an 8 MHz tick, a 125 ns slot.

The divisor is taken in with a load strobe, and only while the block is disabled. A load clears the period counter and the accumulator, so the next enable starts a clean phase. A divisor with a whole part below the minimum, a zero denominator, or a numerator not below the denominator is rejected. A rejected divisor raises an error flag and keeps the tick silent until a valid load replaces it. Dropping the enable pauses the block: the phase within the period and the fraction state are both kept.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, tick and cfg_err are 0, and the divisor is N = RST_DIV (10), b = 0, a = 1.
- R2: With a valid divisor and en held high, tick is high for exactly one cycle per period, and it is never high on two consecutive cycles.
- R3: After a load, tick first rises in the cycle after the N-th rising edge on which en is sampled high. The period counter never exceeds N.
- R4: When b = 0, every period between ticks is exactly N cycles.
- R5: On each tick, b is added to the accumulator. If the sum is at least a, a is subtracted and the next period lasts N + 1 cycles; otherwise the next period lasts N cycles. Any a consecutive periods therefore total a·N + b cycles, and the accumulator always stays below a.
- R6: A load with N < MIN_DIV (2), a = 0 or b ≥ a sets cfg_err one cycle later. While cfg_err is 1, tick stays 0. A later valid load clears cfg_err.
- R7: A load strobe sampled while en is 1 is ignored: the divisor, the phase and cfg_err are unchanged.
- R8: While en is 0, no tick is produced and the phase and accumulator hold. On re-enable, counting continues from where it stopped.
- R9: A load sampled while en is 0 clears the period counter and the accumulator, and the next period is an unstretched N-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low pauses the divider |
| load | input | 1 | Latch div_int/frac_num/frac_den (only while en is 0) |
| div_int | input | DIV_W | Whole part N of the divisor |
| frac_num | input | FRAC_W | Fraction numerator b |
| frac_den | input | FRAC_W | Fraction denominator a |
| tick | output | 1 | One-cycle enable tick |
| cfg_err | output | 1 | Latched divisor is invalid |

## Verification
The load strobe and the running count can meet in the same cycle. The bench raises load while en is high, in the middle of a fractional sequence, and expects the divisor, the phase and the stretch pattern to continue unchanged. A period end can also coincide with en falling or rising. The bench toggles en in an irregular pattern over period boundaries and compares tick on every clock against a behavioural model of the counting rules. Tick timestamps are also recorded, to check the first-tick delay, the constant periods when b = 0, and the a·N + b total over a fractional cycle.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  localparam int DEF_DIV_W   = 8;
  localparam int DEF_FRAC_W  = 6;
  localparam int DEF_MIN_DIV = 2;
  localparam int DEF_RST_DIV = 10;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } mode_e;
endpackage

// File: rtl/ftg_cfg_latch.sv
module ftg_cfg_latch #(
  parameter int DIV_W   = 8,
  parameter int FRAC_W  = 6,
  parameter int MIN_DIV = 2,
  parameter int RST_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [FRAC_W-1:0] num_in,
  input  logic [FRAC_W-1:0] den_in,
  output logic [DIV_W-1:0]  div_q,
  output logic [FRAC_W-1:0] num_q,
  output logic [FRAC_W-1:0] den_q,
  output logic              err_q
);
  localparam logic [DIV_W-1:0]  MIN_V = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0]  RST_V = DIV_W'(RST_DIV);
  localparam logic [FRAC_W-1:0] ONE_V = FRAC_W'(1);

  logic bad;
  always_comb begin
    bad = (div_in < MIN_V) || (den_in == '0) || (num_in >= den_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= RST_V;
      num_q <= '0;
      den_q <= ONE_V;
      err_q <= 1'b0;
    end else if (take) begin
      div_q <= div_in;
      num_q <= num_in;
      den_q <= den_in;
      err_q <= bad;
    end
  end
endmodule

// File: rtl/ftg_frac_acc.sv
module ftg_frac_acc #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic [FRAC_W-1:0] acc_o,
  output logic              stretch_o
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic              str_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  diff;
  logic              over;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, num};
    diff = sum - {1'b0, den};
    over = (sum >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      str_q <= 1'b0;
    end else if (step) begin
      acc_q <= over ? diff[FRAC_W-1:0] : sum[FRAC_W-1:0];
      str_q <= over;
    end
  end

  assign acc_o     = acc_q;
  assign stretch_o = str_q;
endmodule

// File: rtl/ftg_period_cnt.sv
module ftg_period_cnt #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             stretch,
  output logic [DIV_W:0]   cnt_o,
  output logic             wrap_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = {1'b0, div} + CNT_W'(stretch) - CNT_W'(1);
    wrap_o = run && (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import ftg_pkg::*;
#(
  parameter int DIV_W   = DEF_DIV_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int MIN_DIV = DEF_MIN_DIV,
  parameter int RST_DIV = DEF_RST_DIV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic              tick,
  output logic              cfg_err
);
  mode_e             mode;
  logic [DIV_W-1:0]  div_w;
  logic [FRAC_W-1:0] num_w;
  logic [FRAC_W-1:0] den_w;
  logic              err_w;
  logic [FRAC_W-1:0] acc_w;
  logic              stretch_w;
  logic [DIV_W:0]    cnt_w;
  logic              wrap_w;
  logic              tick_q;

  // A load while counting is dropped (R7); a fault halts counting (R6).
  always_comb begin
    if (load && !en)      mode = MODE_LOAD;
    else if (en && !err_w) mode = MODE_COUNT;
    else                  mode = MODE_HOLD;
  end

  ftg_cfg_latch #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .MIN_DIV(MIN_DIV), .RST_DIV(RST_DIV)
  ) u_cfg (
    .clk(clk), .rst(rst), .take(mode == MODE_LOAD),
    .div_in(div_int), .num_in(frac_num), .den_in(frac_den),
    .div_q(div_w), .num_q(num_w), .den_q(den_w), .err_q(err_w)
  );

  ftg_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(mode == MODE_LOAD),
    .run(mode == MODE_COUNT), .div(div_w), .stretch(stretch_w),
    .cnt_o(cnt_w), .wrap_o(wrap_w)
  );

  ftg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .clear(mode == MODE_LOAD), .step(wrap_w),
    .num(num_w), .den(den_w), .acc_o(acc_w), .stretch_o(stretch_w)
  );

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= wrap_w;
  end

  assign tick    = tick_q;
  assign cfg_err = err_w;
endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              load,
  input logic              tick,
  input logic              cfg_err,
  input logic [DIV_W:0]    cnt,
  input logic [DIV_W-1:0]  div,
  input logic [FRAC_W-1:0] acc,
  input logic [FRAC_W-1:0] den
);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_err |-> (cnt <= {1'b0, div}));

  p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_err |-> (acc < den));

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !tick);

  p_busy_load_r7: assert property (@(posedge clk) disable iff (rst)
    (load && en) |=> $stable(cfg_err));

  p_pause_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);
endmodule

bind frac_tick_gen frac_tick_gen_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .load(load), .tick(tick), .cfg_err(cfg_err),
  .cnt(cnt_w), .div(div_w), .acc(acc_w), .den(den_w)
);

// File: tb/frac_tick_gen_tb_top.sv
module frac_tick_gen_tb_top;
  localparam int DW = 8;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [DW-1:0] div_int = '0;
  logic [FW-1:0] frac_num = '0;
  logic [FW-1:0] frac_den = '0;
  logic tick;
  logic cfg_err;

  always #2.5 clk = ~clk;

  frac_tick_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .div_int(div_int),
    .frac_num(frac_num), .frac_den(frac_den), .tick(tick), .cfg_err(cfg_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_req = "R1";
  bit comparing = 1'b0;

  // behavioural reference
  int m_n = 10, m_a = 1, m_b = 0, m_rem = 10, m_frac = 0;
  bit m_err = 0, m_tick = 0;
  int stamps[$];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_n = 10; m_a = 1; m_b = 0; m_frac = 0; m_rem = 10;
      m_err = 0; m_tick = 0;
    end else begin
      m_tick = 0;
      if (load && !en) begin
        m_n = div_int; m_b = frac_num; m_a = frac_den;
        m_err = (m_n < 2) || (m_a == 0) || (m_b >= m_a);
        m_frac = 0; m_rem = m_n;
      end else if (en && !m_err) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_tick = 1;
          m_frac = m_frac + m_b;
          m_rem = m_n;
          if (m_frac >= m_a) begin
            m_frac = m_frac - m_a;
            m_rem = m_n + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && comparing) begin
      n_tests++;
      if (tick !== m_tick) begin
        n_fail++;
        $display("FAIL %s cyc %0d tick got %b exp %b", cur_req, cyc, tick, m_tick);
      end
      n_tests++;
      if (cfg_err !== m_err) begin
        n_fail++;
        $display("FAIL R6 cyc %0d cfg_err got %b exp %b", cyc, cfg_err, m_err);
      end
      if (tick === 1'b1) stamps.push_back(cyc);
    end
  end

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic do_load(input int n, input int b, input int a);
    div_int = DW'(n); frac_num = FW'(b); frac_den = FW'(a);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick", tick, 0);
    check("R1 cfg_err", cfg_err, 0);
    comparing = 1'b1;

    // default divisor straight after reset (R1, R3)
    cur_req = "R1"; stamps.delete();
    start = cyc; en = 1'b1;
    repeat (25) @(negedge clk);
    en = 1'b0;
    check("R1 first tick after default N", stamps[0] - start, 10);
    check("R2 default period", stamps[1] - stamps[0], 10);

    // integer-only divisor (R9 clears, R3 first tick, R4 constant)
    cur_req = "R9"; do_load(5, 0, 1);
    cur_req = "R4"; stamps.delete();
    start = cyc; en = 1'b1;
    repeat (60) @(negedge clk);
    en = 1'b0;
    check("R3 first tick after load", stamps[0] - start, 5);
    for (int i = 0; i + 1 < stamps.size(); i++)
      check("R4 period", stamps[i+1] - stamps[i], 5);

    // fractional divisor 10 + 3/7
    cur_req = "R9"; do_load(10, 3, 7);
    cur_req = "R5"; stamps.delete();
    start = cyc; en = 1'b1;
    repeat (100) @(negedge clk);
    check("R5 first period", stamps[0] - start, 10);
    check("R5 seven periods", stamps[7] - stamps[0], 73);
    check("R5 stretched 3rd", stamps[3] - stamps[2], 11);
    check("R5 plain 2nd", stamps[2] - stamps[1], 10);

    // load while running is ignored
    cur_req = "R7"; stamps.delete();
    do_load(3, 0, 1);
    repeat (40) @(negedge clk);
    check("R7 cfg_err kept", cfg_err, 0);
    for (int i = 0; i + 1 < stamps.size(); i++)
      n_tests += 0;
    check("R7 period not 3", ((stamps[1] - stamps[0]) >= 10) ? 1 : 0, 1);

    // irregular pausing over period boundaries
    cur_req = "R8";
    for (int i = 0; i < 80; i++) begin
      en = ((i % 7) < 4) || ((i % 11) == 5);
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
    check("R8 no tick while paused", tick, 0);

    // invalid divisors
    cur_req = "R6";
    do_load(1, 0, 1);
    check("R6 err on N<2", cfg_err, 1);
    en = 1'b1; stamps.delete();
    repeat (30) @(negedge clk);
    en = 1'b0;
    check("R6 silent ticks", stamps.size(), 0);
    do_load(4, 0, 0);
    check("R6 err on a=0", cfg_err, 1);
    do_load(4, 5, 5);
    check("R6 err on b>=a", cfg_err, 1);
    do_load(2, 2, 3);
    check("R6 err cleared", cfg_err, 0);

    // fastest legal divisor, fractional
    cur_req = "R2"; stamps.delete();
    start = cyc; en = 1'b1;
    repeat (40) @(negedge clk);
    en = 1'b0;
    check("R2 first tick N=2", stamps[0] - start, 2);
    check("R2 three periods", stamps[3] - stamps[0], 8);
    @(negedge clk);
    summary();
  end
endmodule